// File: doc/BRIEF.md
# Limited Pointer Sharer Directory

This block keeps, for every line of a coherence domain, a small fixed set of pointer slots. Each slot holds a valid flag and the identifier of one processor that holds a copy of the line. It replaces a per-processor presence vector. The storage per line grows with the logarithm of the processor count rather than with the count itself. In exchange, a line can record only a bounded number of sharers.

Requests arrive one at a time on a valid/ready port that carries a read/write flag, the requesting processor and the line. A read from a processor that is not yet recorded fills the lowest free slot. When every slot of the line is taken, the block evicts one recorded sharer. It sends an invalidation to that sharer and gives its slot to the requester. A per-line round-robin index picks the victim. A write walks all slots of the line and invalidates every recorded sharer other than the writer. After the walk, the writer is the only sharer left.

The control is a three-state machine:
- `ST_IDLE`: accepts a request. Reads that hit or that find a free slot complete here.
- `ST_EVICT`: one cycle that issues the eviction invalidation and reuses the slot.
- `ST_WALK`: one cycle per slot of a write.

The transitions are:
- IDLE→WALK on an accepted write.
- IDLE→EVICT on an accepted read that misses on a full line.
- EVICT→IDLE always.
- WALK→IDLE after the last slot.

Top module: `lpd_dir`

## Requirements
- R1: After reset, every slot of every line is invalid and every round-robin index is 0. `req_ready` is 1 and `inv_valid` is 0. A write to any line then produces no invalidation.
- R2: `req_ready` is 1 only in the idle state. A request presented while `req_ready` is 0 is not taken and must be held. `inv_valid` is never 1 while `req_ready` is 1.
- R3: A read by a processor not recorded on the line, when the line has a free slot, records it in the lowest-numbered free slot. It issues no invalidation, and `req_ready` stays 1 in the next cycle.
- R4: A read by a processor already recorded on the line changes nothing and issues no invalidation.
- R5: A read by an unrecorded processor on a full line makes `req_ready` 0 for exactly the next cycle. In that cycle, `inv_valid` is 1, `inv_proc` is the processor in the slot named by the line's round-robin index, and `inv_line` is the request line. That slot then holds the requester, and the index advances by one, modulo the slot count.
- R6: An accepted write makes `req_ready` 0 for the next `NUM_PTRS` cycles. In the k-th of these cycles (k from 0), slot k is examined. `inv_valid` is 1, with `inv_proc` set to that slot's processor, exactly when the slot is valid and holds a processor other than the writer. `inv_line` equals the request line throughout.
- R7: After a write, only slot 0 is valid and it holds the writer. The line's round-robin index is left unchanged.
- R8: Requests to one line never change the slots or index of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_proc | input | $clog2(NUM_PROCS) | Requesting processor |
| req_line | input | $clog2(NUM_LINES) | Line addressed |
| req_ready | output | 1 | Request accepted this cycle when high |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_proc | output | $clog2(NUM_PROCS) | Processor to invalidate |
| inv_line | output | $clog2(NUM_LINES) | Line to invalidate |

## Verification
The slot contents are never visible directly, so a corrupted slot, valid flag or round-robin index shows up only when a later request reads it. Such a fault becomes visible at the next write to the line, through the order and identity of the invalidations in the walk cycles. It can also appear at the next overflow read, through the victim named one cycle after acceptance. A slot wrongly allocated by a repeated read shows up as an eviction that comes too early. The bench therefore compares ready, invalidation flag, processor and line against its own model on every cycle, and it ends each scenario with a write that exposes the whole sharer set of the line.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_WALK  = 2'd2
    } lpd_state_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SET  = 2'd1,
        CMD_OWN  = 2'd2
    } lpd_cmd_e;
endpackage

// File: rtl/lpd_ptr_store.sv
module lpd_ptr_store
    import lpd_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PTRS  = 4,
    parameter int LW        = 4,
    parameter int PW        = 4,
    parameter int SW        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   rd_line,
    output logic [NUM_PTRS-1:0] rd_vld,
    output logic [PW-1:0]   rd_ids [NUM_PTRS],
    output logic [SW-1:0]   rd_rr,
    input  lpd_cmd_e        cmd,
    input  logic [LW-1:0]   cmd_line,
    input  logic [SW-1:0]   cmd_slot,
    input  logic [PW-1:0]   cmd_proc,
    input  logic            cmd_adv
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_PTRS - 1);

    logic [NUM_PTRS-1:0] vld_q [NUM_LINES];
    logic [PW-1:0]       id_q  [NUM_LINES][NUM_PTRS];
    logic [SW-1:0]       rr_q  [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                vld_q[l] <= '0;
                rr_q[l]  <= '0;
                for (int s = 0; s < NUM_PTRS; s++) begin
                    id_q[l][s] <= '0;
                end
            end
        end else begin
            unique case (cmd)
                CMD_SET: begin
                    vld_q[cmd_line][cmd_slot] <= 1'b1;
                    id_q[cmd_line][cmd_slot]  <= cmd_proc;
                    if (cmd_adv) begin
                        rr_q[cmd_line] <= (rr_q[cmd_line] == LAST_SLOT) ? '0
                                          : rr_q[cmd_line] + SW'(1);
                    end
                end
                CMD_OWN: begin
                    vld_q[cmd_line]   <= NUM_PTRS'(1);
                    id_q[cmd_line][0] <= cmd_proc;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_vld = vld_q[rd_line];
        rd_rr  = rr_q[rd_line];
        for (int s = 0; s < NUM_PTRS; s++) begin
            rd_ids[s] = id_q[rd_line][s];
        end
    end
endmodule

// File: rtl/lpd_slot_find.sv
module lpd_slot_find #(
    parameter int NUM_PTRS = 4,
    parameter int PW       = 4,
    parameter int SW       = 2
) (
    input  logic [NUM_PTRS-1:0] vld,
    input  logic [PW-1:0]       ids [NUM_PTRS],
    input  logic [PW-1:0]       proc,
    output logic                hit,
    output logic                has_free,
    output logic [SW-1:0]       free_idx
);
    logic [NUM_PTRS-1:0] match;

    for (genvar s = 0; s < NUM_PTRS; s++) begin : g_match
        assign match[s] = vld[s] && (ids[s] == proc);
    end

    assign hit      = |match;
    assign has_free = ~&vld;

    always_comb begin
        free_idx = '0;
        for (int s = NUM_PTRS - 1; s >= 0; s--) begin
            if (!vld[s]) begin
                free_idx = SW'(s);
            end
        end
    end
endmodule

// File: rtl/lpd_dir.sv
module lpd_dir
    import lpd_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PTRS  = 4,
    parameter int NUM_PROCS = 16,
    localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int PW = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
    localparam int SW = (NUM_PTRS  > 1) ? $clog2(NUM_PTRS)  : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [PW-1:0] req_proc,
    input  logic [LW-1:0] req_line,
    output logic          req_ready,
    output logic          inv_valid,
    output logic [PW-1:0] inv_proc,
    output logic [LW-1:0] inv_line
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_PTRS - 1);

    lpd_state_e    state_q, state_d;
    logic [LW-1:0] cap_line_q;
    logic [PW-1:0] cap_proc_q;
    logic [SW-1:0] walk_q, walk_d;
    logic          cap_en;

    logic [LW-1:0]       rd_line;
    logic [NUM_PTRS-1:0] rd_vld;
    logic [PW-1:0]       rd_ids [NUM_PTRS];
    logic [SW-1:0]       rd_rr;
    logic                hit, has_free;
    logic [SW-1:0]       free_idx;

    lpd_cmd_e      cmd;
    logic [LW-1:0] cmd_line;
    logic [SW-1:0] cmd_slot;
    logic [PW-1:0] cmd_proc;
    logic          cmd_adv;

    assign rd_line = (state_q == ST_IDLE) ? req_line : cap_line_q;

    lpd_ptr_store #(
        .NUM_LINES(NUM_LINES), .NUM_PTRS(NUM_PTRS), .LW(LW), .PW(PW), .SW(SW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_line(rd_line), .rd_vld(rd_vld),
        .rd_ids(rd_ids), .rd_rr(rd_rr), .cmd(cmd), .cmd_line(cmd_line),
        .cmd_slot(cmd_slot), .cmd_proc(cmd_proc), .cmd_adv(cmd_adv)
    );

    lpd_slot_find #(.NUM_PTRS(NUM_PTRS), .PW(PW), .SW(SW)) u_find (
        .vld(rd_vld), .ids(rd_ids), .proc(req_proc),
        .hit(hit), .has_free(has_free), .free_idx(free_idx)
    );

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            walk_q     <= '0;
            cap_line_q <= '0;
            cap_proc_q <= '0;
        end else begin
            state_q <= state_d;
            walk_q  <= walk_d;
            if (cap_en) begin
                cap_line_q <= req_line;
                cap_proc_q <= req_proc;
            end
        end
    end

    // Next state and store commands
    always_comb begin
        state_d  = state_q;
        walk_d   = walk_q;
        cap_en   = 1'b0;
        cmd      = CMD_NONE;
        cmd_line = cap_line_q;
        cmd_slot = rd_rr;
        cmd_proc = cap_proc_q;
        cmd_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cap_en = 1'b1;
                    if (req_write) begin
                        state_d = ST_WALK;
                        walk_d  = '0;
                    end else if (!hit) begin
                        if (has_free) begin
                            cmd      = CMD_SET;
                            cmd_line = req_line;
                            cmd_slot = free_idx;
                            cmd_proc = req_proc;
                        end else begin
                            state_d = ST_EVICT;
                        end
                    end
                end
            end
            ST_EVICT: begin
                cmd     = CMD_SET;
                cmd_adv = 1'b1;
                state_d = ST_IDLE;
            end
            ST_WALK: begin
                if (walk_q == LAST_SLOT) begin
                    cmd     = CMD_OWN;
                    state_d = ST_IDLE;
                end else begin
                    walk_d = walk_q + SW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        inv_valid = 1'b0;
        inv_proc  = '0;
        inv_line  = cap_line_q;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_EVICT: begin
                inv_valid = 1'b1;
                inv_proc  = rd_ids[rd_rr];
            end
            ST_WALK: begin
                inv_valid = rd_vld[walk_q] && (rd_ids[walk_q] != cap_proc_q);
                inv_proc  = rd_ids[walk_q];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpd_dir_chk.sv
module lpd_dir_chk
    import lpd_pkg::*;
#(
    parameter int NUM_PTRS = 4,
    parameter int PW       = 4,
    parameter int LW       = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic          inv_valid,
    input logic [PW-1:0] inv_proc,
    input logic [LW-1:0] inv_line,
    input lpd_state_e    state,
    input logic [PW-1:0] cap_proc
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (!req_ready) busy_cnt <= busy_cnt + 1;
        else busy_cnt <= 0;
    end

    assert_inv_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> !req_ready);

    assert_write_goes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> !req_ready);

    assert_no_self_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WALK && inv_valid) |-> (inv_proc != cap_proc));

    assert_evict_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT) |=> req_ready);

    assert_line_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(inv_line));

    assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= NUM_PTRS);
endmodule

bind lpd_dir lpd_dir_chk #(.NUM_PTRS(NUM_PTRS), .PW(PW), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .inv_valid(inv_valid), .inv_proc(inv_proc),
    .inv_line(inv_line), .state(state_q), .cap_proc(cap_proc_q)
);

// File: tb/sim_lpd_dir.sv
module sim_lpd_dir;
    localparam int LINES = 16;
    localparam int PTRS  = 4;
    localparam int PROCS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [3:0] req_proc = '0;
    logic [3:0] req_line = '0;
    logic       req_ready, inv_valid;
    logic [3:0] inv_proc, inv_line;

    lpd_dir #(.NUM_LINES(LINES), .NUM_PTRS(PTRS), .NUM_PROCS(PROCS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_proc(req_proc), .req_line(req_line), .req_ready(req_ready),
        .inv_valid(inv_valid), .inv_proc(inv_proc), .inv_line(inv_line)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    v;
        int    p;
        int    l;
        string tag;
    } ev_t;

    ev_t   exp_q[$];
    bit    m_vld [LINES][PTRS];
    int    m_id  [LINES][PTRS];
    int    m_rr  [LINES];
    string idle_tag = "R1";
    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 0;
    bit    accepted;
    int    seed = 12345;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural model of one accepted request
    task automatic model_apply(input bit w, input int p, input int l);
        if (w) begin
            for (int s = 0; s < PTRS; s++) begin
                ev_t e;
                e.v = m_vld[l][s] && (m_id[l][s] != p);
                e.p = m_id[l][s];
                e.l = l;
                e.tag = "R6";
                exp_q.push_back(e);
            end
            for (int s = 0; s < PTRS; s++) m_vld[l][s] = 0;
            m_vld[l][0] = 1;   // R7: writer alone in slot 0
            m_id[l][0]  = p;
            idle_tag = "R7";
        end else begin
            int fr;
            bit hit;
            hit = 0;
            fr = -1;
            for (int s = 0; s < PTRS; s++)
                if (m_vld[l][s] && m_id[l][s] == p) hit = 1;
            for (int s = PTRS - 1; s >= 0; s--)
                if (!m_vld[l][s]) fr = s;
            if (hit) begin
                idle_tag = "R4";
            end else if (fr >= 0) begin
                m_vld[l][fr] = 1;
                m_id[l][fr]  = p;
                idle_tag = "R3";
            end else begin
                ev_t e;
                e.v = 1;
                e.p = m_id[l][m_rr[l]];
                e.l = l;
                e.tag = "R5";
                exp_q.push_back(e);
                m_id[l][m_rr[l]] = p;
                m_rr[l] = (m_rr[l] + 1) % PTRS;
                idle_tag = "R5";
            end
        end
    endtask

    // One clock: check outputs away from the edge, then advance the model
    task automatic cycle();
        if (exp_q.size() > 0) begin
            ev_t e;
            e = exp_q[0];
            chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
            chk(inv_valid == e.v, e.tag, int'(inv_valid), int'(e.v));
            if (e.v) begin
                chk(int'(inv_proc) == e.p, e.tag, int'(inv_proc), e.p);
                chk(int'(inv_line) == e.l, e.tag, int'(inv_line), e.l);
            end
            void'(exp_q.pop_front());
            accepted = 0;
        end else begin
            chk(req_ready == 1'b1, idle_tag, int'(req_ready), 1);
            chk(inv_valid == 1'b0, "R2", int'(inv_valid), 0);
            accepted = req_valid;
            if (req_valid) model_apply(req_write, int'(req_proc), int'(req_line));
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Hold a request until the model says it is taken (R2)
    task automatic do_req(input bit w, input int p, input int l);
        req_valid = 1'b1;
        req_write = w;
        req_proc  = 4'(p);
        req_line  = 4'(l);
        accepted  = 0;
        while (!accepted) cycle();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) cycle();
        cycle();
    endtask

    initial begin
        for (int l = 0; l < LINES; l++) begin
            m_rr[l] = 0;
            for (int s = 0; s < PTRS; s++) begin
                m_vld[l][s] = 0;
                m_id[l][s]  = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then a write on an empty line gives no invalidation
        cycle();
        do_req(1, 5, 3);
        drain();
        // R3 / R4: fill line 1 with a repeated read in between
        do_req(0, 1, 1); do_req(0, 2, 1); do_req(0, 2, 1);
        do_req(0, 3, 1); do_req(0, 4, 1);
        // R5: overflow evicts slot 0 then slot 1
        do_req(0, 6, 1); do_req(0, 7, 1);
        do_req(0, 6, 1);
        // R6: walk shows slot order p6, p7, (p3 skipped), p4
        do_req(1, 3, 1);
        // R7: writer alone in slot 0, next read goes to slot 1
        do_req(0, 8, 1);
        do_req(1, 9, 1);
        drain();
        // R8: lines are independent
        do_req(0, 1, 2);
        do_req(1, 2, 5);
        do_req(1, 4, 2);
        drain();
        // R5 wrap of the round-robin index
        for (int p = 0; p < 4; p++) do_req(0, p, 7);
        for (int p = 10; p < 15; p++) do_req(0, p, 7);
        // R7: write keeps the index (now 1)
        do_req(1, 5, 7);
        do_req(0, 6, 7); do_req(0, 7, 7); do_req(0, 8, 7);
        do_req(0, 9, 7);
        do_req(1, 0, 7);
        drain();
        // Mixed traffic on a few lines
        for (int i = 0; i < 300; i++) begin
            int r;
            seed = seed * 1103515245 + 12345;
            r = (seed >>> 8) & 32'h7fff;
            do_req((r % 7) == 0, (r >> 3) % PROCS, (r >> 7) % 3);
        end
        for (int l = 0; l < 3; l++) do_req(1, 15, l);
        drain();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule